// File: doc/BRIEF.md
# Configurable Product-Term Logic Macrocell

This block is one logic cell of a programmable logic fabric. It receives five product terms that an upstream AND array has already formed. It also receives a sum passed along from the neighbouring cell, a pad input, three global clocks, a global clear and two global output-enable lines. A static configuration word chooses how each of these is used. The terms can go into an OR sum. A second operand turns that sum through an XOR for polarity control. The storage element takes its data from one of three sources, and the cell picks its own clock, clock enable, asynchronous reset, asynchronous preset and output enable.

The storage element works as a D, T, JK or SR flip-flop on the rising edge of the selected clock, or as a level-sensitive latch. The pad output and the buried feedback can each be taken from the stored bit or from the combinational XOR result, independently of each other. The cell passes its OR sum to the next cell, so chained cells can build wide sums: eight cells give forty terms. It also returns an inverted copy of one chosen product term as a foldback signal.

Top module: `mc_cell`

## Requirements
- R1: The OR sum is the OR of every product term whose bit is set in the 5-bit term mask (bit n selects term n), plus the cascade input when the cascade-enable bit is 1. The cascade output always equals this sum.
- R2: The XOR result is the OR sum XORed with a second operand: constant 0 when the XOR mode is 0, constant 1 when it is 1, and the product term named by the XOR index when it is 2 or 3.
- R3: The storage data is the XOR result when the data source is 0, the product term named by the data index when it is 1, and the pad input when it is 2 or 3.
- R4: In mode 0 (D) the stored bit takes the data on a rising clock edge. In mode 1 (T) it inverts on an edge when the data is 1 and holds when the data is 0.
- R5: In mode 2 (JK) term 0 is J and term 1 is K: 10 sets, 01 clears, 11 inverts, 00 holds. In mode 3 (SR) term 0 is set and term 1 is reset: 10 sets, 01 clears, and 11 or 00 hold.
- R6: In mode 4 (latch) the stored bit follows the data while the selected clock is high and holds while it is low.
- R7: Clock source values 0, 1 and 2 select global clocks 0, 1 and 2. Value 3 selects the product term named by the clock index. A clock that is not selected has no effect.
- R8: With a global clock selected and the clock-enable bit set, edges that arrive while the product term named by the enable index is low leave the stored bit unchanged. With the product-term clock, that enable is ignored.
- R9: The reset mode selects the asynchronous reset: 0 none, 1 global clear, 2 the term named by the reset index, 3 the OR of both. When the preset-enable bit is set, the term named by the preset index presets the bit to 1. Reset wins when both are active. With reset mode 0 the global clear has no effect, and reset forces the pad output to 0 when the output is registered.
- R10: The pad output is the stored bit when the output-register bit is 1 and the XOR result otherwise. The feedback output uses the feedback-register bit in the same way, independently of the pad output.
- R11: The foldback output is the inverse of the product term named by the foldback index.
- R12: The output enable is global OE 0 for OE mode 0, its inverse for 1, global OE 1 for 2, its inverse for 3, and the term named by the OE index for 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg | input | 48 | Static configuration word (packed record `mc_cfg_t`) |
| pt | input | 5 | Product terms from the AND array |
| casc_in | input | 1 | Sum from the preceding cell of the chain |
| pin_in | input | 1 | Pad input value |
| gclk | input | 3 | Global clocks |
| gclr | input | 1 | Global clear, active high |
| goe | input | 2 | Global output-enable lines |
| pad_out | output | 1 | Pad output data |
| pad_oe | output | 1 | Pad output enable |
| fb_out | output | 1 | Buried feedback to the global bus |
| casc_out | output | 1 | Sum passed to the next cell |
| fold_out | output | 1 | Inverted selected product term |

## Verification
A vector table applies term and cascade patterns to a fixed routing. Masked-out terms toggle without effect, and the XOR term flips polarity only when it is set, which separates the term mask, the cascade path and the XOR operand from each other. Directed sequences drive J/K and S/R pairs through every combination from a known cleared state, so hold, set, clear and toggle each give a different result. The latch is probed mid-phase on both clock levels. Unselected clocks, a low clock enable, and a global clear that the configuration does not use are each driven while the stored bit holds the opposite value of what they would produce. Overlapping reset and preset show which one wins.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
  localparam int N_PT   = 5;
  localparam int N_GCLK = 3;
  localparam int IDX_W  = $clog2(N_PT);
  localparam int CSRC_W = $clog2(N_GCLK + 1);

  typedef enum logic [2:0] {
    ST_D   = 3'd0,
    ST_T   = 3'd1,
    ST_JK  = 3'd2,
    ST_SR  = 3'd3,
    ST_LAT = 3'd4
  } st_mode_e;

  localparam logic [1:0] XM_ZERO = 2'd0;
  localparam logic [1:0] XM_ONE  = 2'd1;
  localparam logic [1:0] XM_PT   = 2'd2;

  localparam logic [1:0] DS_XOR  = 2'd0;
  localparam logic [1:0] DS_PT   = 2'd1;
  localparam logic [1:0] DS_PIN  = 2'd2;

  localparam logic [1:0] AR_OFF  = 2'd0;
  localparam logic [1:0] AR_GCLR = 2'd1;
  localparam logic [1:0] AR_PT   = 2'd2;
  localparam logic [1:0] AR_BOTH = 2'd3;

  localparam logic [2:0] OE_G0   = 3'd0;
  localparam logic [2:0] OE_G0N  = 3'd1;
  localparam logic [2:0] OE_G1   = 3'd2;
  localparam logic [2:0] OE_G1N  = 3'd3;
  localparam logic [2:0] OE_PT   = 3'd4;

  typedef struct packed {
    logic [N_PT-1:0]   sum_mask;
    logic              casc_en;
    logic [1:0]        xor_mode;
    logic [IDX_W-1:0]  xor_pt;
    logic [1:0]        d_src;
    logic [IDX_W-1:0]  d_pt;
    st_mode_e          st_mode;
    logic [CSRC_W-1:0] clk_src;
    logic [IDX_W-1:0]  clk_pt;
    logic              ce_en;
    logic [IDX_W-1:0]  ce_pt;
    logic [1:0]        ar_mode;
    logic [IDX_W-1:0]  ar_pt;
    logic              ap_en;
    logic [IDX_W-1:0]  ap_pt;
    logic              out_reg;
    logic              fb_reg;
    logic [IDX_W-1:0]  fold_pt;
    logic [2:0]        oe_mode;
    logic [IDX_W-1:0]  oe_pt;
  } mc_cfg_t;

  localparam int CFG_W = $bits(mc_cfg_t);

  // Select one product term by index; indices past the last term read as 0.
  function automatic logic pick_pt(input logic [N_PT-1:0] v,
                                   input logic [IDX_W-1:0] idx);
    logic r;
    r = 1'b0;
    for (int n = 0; n < N_PT; n++) begin
      if (idx == IDX_W'(n)) r = v[n];
    end
    return r;
  endfunction
endpackage

// File: rtl/mc_sum.sv
`timescale 1ns/1ps
module mc_sum
  import mc_pkg::*;
(
  input  logic [N_PT-1:0]  pt,
  input  logic             casc_in,
  input  logic [N_PT-1:0]  sum_mask,
  input  logic             casc_en,
  input  logic [1:0]       xor_mode,
  input  logic [IDX_W-1:0] xor_pt,
  output logic             sum,
  output logic             xor_out
);
  logic [N_PT-1:0] gated;
  logic            operand;

  genvar g;
  generate
    for (g = 0; g < N_PT; g++) begin : g_gate
      assign gated[g] = pt[g] & sum_mask[g];
    end
  endgenerate

  always_comb begin
    sum = (|gated) | (casc_en & casc_in);
    unique case (xor_mode)
      XM_ZERO: operand = 1'b0;
      XM_ONE:  operand = 1'b1;
      default: operand = pick_pt(pt, xor_pt);
    endcase
    xor_out = sum ^ operand;
  end
endmodule

// File: rtl/mc_ctrl.sv
`timescale 1ns/1ps
module mc_ctrl
  import mc_pkg::*;
(
  input  logic [N_PT-1:0]   pt,
  input  logic [N_GCLK-1:0] gclk,
  input  logic              gclr,
  input  logic [1:0]        goe,
  input  logic [CSRC_W-1:0] clk_src,
  input  logic [IDX_W-1:0]  clk_pt,
  input  logic              ce_en,
  input  logic [IDX_W-1:0]  ce_pt,
  input  logic [1:0]        ar_mode,
  input  logic [IDX_W-1:0]  ar_pt,
  input  logic              ap_en,
  input  logic [IDX_W-1:0]  ap_pt,
  input  logic [2:0]        oe_mode,
  input  logic [IDX_W-1:0]  oe_pt,
  output logic              clk_sel,
  output logic              ce,
  output logic              ar,
  output logic              ap,
  output logic              oe
);
  logic from_global;

  always_comb begin
    clk_sel     = pick_pt(pt, clk_pt);
    from_global = 1'b0;
    for (int i = 0; i < N_GCLK; i++) begin
      if (clk_src == CSRC_W'(i)) begin
        clk_sel     = gclk[i];
        from_global = 1'b1;
      end
    end
    ce = (from_global && ce_en) ? pick_pt(pt, ce_pt) : 1'b1;
  end

  always_comb begin
    unique case (ar_mode)
      AR_GCLR: ar = gclr;
      AR_PT:   ar = pick_pt(pt, ar_pt);
      AR_BOTH: ar = gclr | pick_pt(pt, ar_pt);
      default: ar = 1'b0;
    endcase
    ap = ap_en & pick_pt(pt, ap_pt);
  end

  always_comb begin
    case (oe_mode)
      OE_G0:   oe = goe[0];
      OE_G0N:  oe = ~goe[0];
      OE_G1:   oe = goe[1];
      OE_G1N:  oe = ~goe[1];
      OE_PT:   oe = pick_pt(pt, oe_pt);
      default: oe = 1'b0;
    endcase
  end
endmodule

// File: rtl/mc_store.sv
`timescale 1ns/1ps
module mc_store
  import mc_pkg::*;
(
  input  logic     clk,
  input  logic     ce,
  input  logic     ar,
  input  logic     ap,
  input  st_mode_e mode,
  input  logic     d,
  input  logic     ctl_a,
  input  logic     ctl_b,
  output logic     q
);
  logic ff_q;
  logic ff_nxt;
  logic lat_q;

  always_comb begin
    unique case (mode)
      ST_T:  ff_nxt = ff_q ^ d;
      ST_JK: ff_nxt = ({ctl_a, ctl_b} == 2'b10) ? 1'b1 :
                      ({ctl_a, ctl_b} == 2'b01) ? 1'b0 :
                      ({ctl_a, ctl_b} == 2'b11) ? ~ff_q : ff_q;
      ST_SR: ff_nxt = ({ctl_a, ctl_b} == 2'b10) ? 1'b1 :
                      ({ctl_a, ctl_b} == 2'b01) ? 1'b0 : ff_q;
      default: ff_nxt = d;
    endcase
  end

  always_ff @(posedge clk or posedge ar or posedge ap) begin
    if (ar)      ff_q <= 1'b0;
    else if (ap) ff_q <= 1'b1;
    else if (ce) ff_q <= ff_nxt;
  end

  always_latch begin
    if (ar)              lat_q = 1'b0;
    else if (ap)         lat_q = 1'b1;
    else if (clk && ce)  lat_q = d;
  end

  assign q = (mode == ST_LAT) ? lat_q : ff_q;
endmodule

// File: rtl/mc_cell.sv
`timescale 1ns/1ps
module mc_cell
  import mc_pkg::*;
(
  input  logic [CFG_W-1:0]  cfg,
  input  logic [N_PT-1:0]   pt,
  input  logic              casc_in,
  input  logic              pin_in,
  input  logic [N_GCLK-1:0] gclk,
  input  logic              gclr,
  input  logic [1:0]        goe,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              fb_out,
  output logic              casc_out,
  output logic              fold_out
);
  mc_cfg_t c;
  logic    sum, xo, d_sel;
  logic    clk_sel, ce, ar, ap, oe, q;

  assign c = mc_cfg_t'(cfg);

  mc_sum u_sum (
    .pt       (pt),
    .casc_in  (casc_in),
    .sum_mask (c.sum_mask),
    .casc_en  (c.casc_en),
    .xor_mode (c.xor_mode),
    .xor_pt   (c.xor_pt),
    .sum      (sum),
    .xor_out  (xo)
  );

  mc_ctrl u_ctrl (
    .pt      (pt),
    .gclk    (gclk),
    .gclr    (gclr),
    .goe     (goe),
    .clk_src (c.clk_src),
    .clk_pt  (c.clk_pt),
    .ce_en   (c.ce_en),
    .ce_pt   (c.ce_pt),
    .ar_mode (c.ar_mode),
    .ar_pt   (c.ar_pt),
    .ap_en   (c.ap_en),
    .ap_pt   (c.ap_pt),
    .oe_mode (c.oe_mode),
    .oe_pt   (c.oe_pt),
    .clk_sel (clk_sel),
    .ce      (ce),
    .ar      (ar),
    .ap      (ap),
    .oe      (oe)
  );

  always_comb begin
    unique case (c.d_src)
      DS_XOR:  d_sel = xo;
      DS_PT:   d_sel = pick_pt(pt, c.d_pt);
      default: d_sel = pin_in;
    endcase
  end

  mc_store u_store (
    .clk   (clk_sel),
    .ce    (ce),
    .ar    (ar),
    .ap    (ap),
    .mode  (c.st_mode),
    .d     (d_sel),
    .ctl_a (pt[0]),
    .ctl_b (pt[1]),
    .q     (q)
  );

  assign pad_out  = c.out_reg ? q : xo;
  assign fb_out   = c.fb_reg  ? q : xo;
  assign pad_oe   = oe;
  assign casc_out = sum;
  assign fold_out = ~pick_pt(pt, c.fold_pt);
endmodule

// File: rtl/mc_cell_chk.sv
`timescale 1ns/1ps
module mc_cell_chk
  import mc_pkg::*;
(
  input logic            gclk0,
  input logic            gclr,
  input mc_cfg_t         c,
  input logic [N_PT-1:0] pt,
  input logic            d,
  input logic            ce,
  input logic            ar,
  input logic            ap,
  input logic            q
);
  logic on_g0;
  assign on_g0 = (c.clk_src == '0);

  // R9: an active reset forces the stored bit low, even with preset active
  p_reset_wins_r9: assert property (@(posedge gclk0) disable iff (gclr)
    ar |-> (q == 1'b0));

  // R9: preset alone forces the stored bit high
  p_preset_r9: assert property (@(posedge gclk0) disable iff (gclr)
    (ap && !ar) |-> (q == 1'b1));

  // R4: D mode on global clock 0 captures the data
  p_dcap_r4: assert property (@(posedge gclk0) disable iff (gclr)
    (on_g0 && c.st_mode == ST_D && ce && !ar && !ap)
    |=> (q == $past(d) || ar || ap || !$stable(c)));

  // R4: T mode with data 1 inverts the stored bit
  p_toggle_r4: assert property (@(posedge gclk0) disable iff (gclr)
    (on_g0 && c.st_mode == ST_T && ce && d && !ar && !ap)
    |=> (q != $past(q) || ar || ap || !$stable(c)));

  // R5: SR mode with both inputs high holds
  p_sr_hold_r5: assert property (@(posedge gclk0) disable iff (gclr)
    (on_g0 && c.st_mode == ST_SR && ce && pt[0] && pt[1] && !ar && !ap)
    |=> ($stable(q) || ar || ap || !$stable(c)));

  // R8: a low clock enable leaves the flip-flop unchanged
  p_ce_hold_r8: assert property (@(posedge gclk0) disable iff (gclr)
    (on_g0 && c.st_mode != ST_LAT && !ce && !ar && !ap)
    |=> ($stable(q) || ar || ap || !$stable(c)));
endmodule

bind mc_cell mc_cell_chk u_chk (
  .gclk0 (gclk[0]),
  .gclr  (gclr),
  .c     (c),
  .pt    (pt),
  .d     (d_sel),
  .ce    (ce),
  .ar    (ar),
  .ap    (ap),
  .q     (q)
);

// File: tb/mc_cell_bench.sv
`timescale 1ns/1ps
module mc_cell_bench;
  import mc_pkg::*;

  localparam int CLK_P = 10;

  // {pt[4:0], casc_in, exp pad_out, exp casc_out, exp fold_out}
  localparam logic [8:0] VEC [8] = '{
    9'b00000_0_0_0_1,
    9'b00001_0_1_1_1,
    9'b10001_0_0_1_1,
    9'b10000_0_1_0_1,
    9'b01000_0_0_0_0,
    9'b00000_1_1_1_1,
    9'b11100_0_0_1_0,
    9'b00010_1_1_1_1
  };

  logic [CFG_W-1:0] cfg;
  logic [N_PT-1:0]  pt;
  logic             casc_in, pin_in, gclr;
  logic             clk0, g1, g2;
  logic [1:0]       goe;
  logic [N_GCLK-1:0] gclk;
  logic pad_out, pad_oe, fb_out, casc_out, fold_out;

  int n_chk  = 0;
  int n_fail = 0;
  mc_cfg_t c;

  assign gclk = {g2, g1, clk0};

  mc_cell u_mc_cell (
    .cfg(cfg), .pt(pt), .casc_in(casc_in), .pin_in(pin_in), .gclk(gclk),
    .gclr(gclr), .goe(goe), .pad_out(pad_out), .pad_oe(pad_oe),
    .fb_out(fb_out), .casc_out(casc_out), .fold_out(fold_out)
  );

  initial begin
    clk0 = 1'b0;
    forever #(CLK_P/2) clk0 = ~clk0;
  end

  task automatic chk(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic mc_cfg_t base();
    mc_cfg_t b;
    b = '0;
    b.ar_mode = AR_GCLR;
    b.out_reg = 1'b1;
    b.fb_reg  = 1'b1;
    b.st_mode = ST_D;
    return b;
  endfunction

  task automatic apply(input mc_cfg_t nc);
    @(negedge clk0);
    cfg = nc; pt = '0; pin_in = 1'b0; casc_in = 1'b0; goe = 2'b01;
  endtask

  task automatic clear();
    @(negedge clk0); gclr = 1'b1;
    @(negedge clk0); gclr = 1'b0;
  endtask

  task automatic step_pt(input logic [N_PT-1:0] v, input logic exp, input string tag);
    @(negedge clk0); pt = v;
    @(posedge clk0); #2;
    chk(pad_out, exp, tag);
  endtask

  initial begin
    #(CLK_P*50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    g1 = 1'b0; g2 = 1'b0; gclr = 1'b1;
    pt = '0; pin_in = 1'b0; casc_in = 1'b0; goe = 2'b01;
    c = base(); c.xor_mode = XM_ONE; cfg = c;

    // Reset state (R9) then D capture (R4)
    repeat (3) @(posedge clk0);
    #2;
    chk(pad_out, 1'b0, "R9 reset pad_out");
    chk(fb_out,  1'b0, "R9 reset fb_out");
    @(negedge clk0); gclr = 1'b0;
    @(posedge clk0); #2;
    chk(pad_out, 1'b1, "R4 D capture after reset");

    // Vector table: sum, cascade, XOR operand, foldback
    c = base(); c.sum_mask = 5'b00111; c.casc_en = 1'b1;
    c.xor_mode = XM_PT; c.xor_pt = 3'd4; c.fold_pt = 3'd3; c.out_reg = 1'b0;
    apply(c);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk0);
      {pt, casc_in} = VEC[i][8:3];
      #2;
      chk(pad_out,  VEC[i][2], $sformatf("R2 xor vec %0d", i));
      chk(casc_out, VEC[i][1], $sformatf("R1 sum vec %0d", i));
      chk(fold_out, VEC[i][0], $sformatf("R11 foldback vec %0d", i));
    end

    // R3 data sources
    c = base(); c.d_src = DS_PIN; apply(c); clear();
    @(negedge clk0); pin_in = 1'b1; @(posedge clk0); #2; chk(pad_out, 1'b1, "R3 pin data 1");
    @(negedge clk0); pin_in = 1'b0; @(posedge clk0); #2; chk(pad_out, 1'b0, "R3 pin data 0");
    c.d_src = DS_PT; c.d_pt = 3'd2; apply(c);
    step_pt(5'b00100, 1'b1, "R3 term data 1");
    step_pt(5'b00000, 1'b0, "R3 term data 0");

    // R4 T mode
    c = base(); c.st_mode = ST_T; c.xor_mode = XM_ONE; apply(c); clear();
    @(posedge clk0); #2; chk(pad_out, 1'b1, "R4 T toggle 1");
    @(posedge clk0); #2; chk(pad_out, 1'b0, "R4 T toggle 2");
    @(negedge clk0); c.xor_mode = XM_ZERO; cfg = c;
    @(posedge clk0); #2; chk(pad_out, 1'b0, "R4 T hold 1");
    @(posedge clk0); #2; chk(pad_out, 1'b0, "R4 T hold 2");

    // R5 JK then SR
    c = base(); c.st_mode = ST_JK; apply(c); clear();
    step_pt(5'b00001, 1'b1, "R5 JK set");
    step_pt(5'b00000, 1'b1, "R5 JK hold");
    step_pt(5'b00010, 1'b0, "R5 JK clear");
    step_pt(5'b00011, 1'b1, "R5 JK toggle a");
    step_pt(5'b00011, 1'b0, "R5 JK toggle b");
    c.st_mode = ST_SR; apply(c); clear();
    step_pt(5'b00011, 1'b0, "R5 SR both hold low");
    step_pt(5'b00001, 1'b1, "R5 SR set");
    step_pt(5'b00011, 1'b1, "R5 SR both hold high");
    step_pt(5'b00010, 1'b0, "R5 SR reset");

    // R6 latch
    c = base(); c.st_mode = ST_LAT; c.d_src = DS_PIN; apply(c); clear();
    @(posedge clk0); #1 pin_in = 1'b1; #1 chk(pad_out, 1'b1, "R6 transparent 1");
    #1 pin_in = 1'b0; #1 chk(pad_out, 1'b0, "R6 transparent 0");
    pin_in = 1'b1;
    @(negedge clk0); #1 pin_in = 1'b0; #1 chk(pad_out, 1'b1, "R6 hold while low");
    @(posedge clk0); #1 chk(pad_out, 1'b0, "R6 reopen");

    // R7 clock sources
    c = base(); c.d_src = DS_PIN; c.clk_src = 2'd3; c.clk_pt = 3'd3;
    apply(c); clear();
    pin_in = 1'b1;
    @(posedge clk0); #2; chk(pad_out, 1'b0, "R7 unselected global clock");
    @(negedge clk0); #1 pt[3] = 1'b1; #1 chk(pad_out, 1'b1, "R7 term clock edge");
    pt[3] = 1'b0;
    @(negedge clk0); c.clk_src = 2'd1; cfg = c; pin_in = 1'b0;
    @(posedge clk0); #2; chk(pad_out, 1'b1, "R7 clock 0 ignored when clock 1 picked");
    #1 g1 = 1'b1; #1 chk(pad_out, 1'b0, "R7 global clock 1 edge");
    g1 = 1'b0;

    // R8 clock enable
    c = base(); c.d_src = DS_PIN; c.ce_en = 1'b1; c.ce_pt = 3'd4; apply(c); clear();
    @(negedge clk0); pin_in = 1'b1; pt[4] = 1'b0;
    @(posedge clk0); #2; chk(pad_out, 1'b0, "R8 enable low ignores edge");
    @(negedge clk0); pt[4] = 1'b1;
    @(posedge clk0); #2; chk(pad_out, 1'b1, "R8 enable high captures");
    @(negedge clk0); c.clk_src = 2'd3; c.clk_pt = 3'd3; cfg = c; pin_in = 1'b0; pt[4] = 1'b0;
    #1 pt[3] = 1'b1; #1 chk(pad_out, 1'b0, "R8 enable ignored on term clock");
    pt[3] = 1'b0;

    // R9 asynchronous reset and preset
    c = base(); c.clk_src = 2'd3; c.clk_pt = 3'd0; c.ar_mode = AR_PT; c.ar_pt = 3'd3;
    c.ap_en = 1'b1; c.ap_pt = 3'd4; apply(c);
    @(negedge clk0); pt[3] = 1'b1; #1 chk(pad_out, 1'b0, "R9 term reset");
    pt[3] = 1'b0; #1 pt[4] = 1'b1; #1 chk(pad_out, 1'b1, "R9 term preset");
    pt[3] = 1'b1; #1 chk(pad_out, 1'b0, "R9 reset wins over preset");
    pt[4] = 1'b0; #1 pt[3] = 1'b0; #1 chk(pad_out, 1'b0, "R9 stays reset");
    @(negedge clk0); c.ar_mode = AR_OFF; cfg = c;
    #1 pt[4] = 1'b1; #1 pt[4] = 1'b0; #1 chk(pad_out, 1'b1, "R9 preset before unused clear");
    gclr = 1'b1;
    @(posedge clk0); #2; chk(pad_out, 1'b1, "R9 global clear ignored when off");
    @(negedge clk0); gclr = 1'b0; c.ar_mode = AR_BOTH; cfg = c;
    #1 pt[3] = 1'b1; #1 chk(pad_out, 1'b0, "R9 OR mode term reset");
    pt[3] = 1'b0; #1 pt[4] = 1'b1; #1 pt[4] = 1'b0;
    #1 chk(pad_out, 1'b1, "R9 preset again");
    gclr = 1'b1; #1 chk(pad_out, 1'b0, "R9 OR mode global clear");
    @(negedge clk0); gclr = 1'b0;

    // R10 output and feedback selection, R2 constants, R1 cascade enable
    c = base(); c.xor_mode = XM_ONE; c.clk_src = 2'd3; c.clk_pt = 3'd0;
    apply(c); clear();
    @(negedge clk0); c.out_reg = 1'b0; c.fb_reg = 1'b1; cfg = c;
    #2 chk(pad_out, 1'b1, "R10 pad combinational");
    chk(fb_out, 1'b0, "R10 feedback registered");
    c.out_reg = 1'b1; c.fb_reg = 1'b0; cfg = c;
    #2 chk(pad_out, 1'b0, "R10 pad registered");
    chk(fb_out, 1'b1, "R10 feedback combinational");
    c.out_reg = 1'b0; c.sum_mask = 5'b00001; c.xor_mode = XM_ZERO; cfg = c; pt[0] = 1'b1;
    #2 chk(pad_out, 1'b1, "R2 constant 0 keeps polarity");
    c.xor_mode = XM_ONE; cfg = c;
    #2 chk(pad_out, 1'b0, "R2 constant 1 inverts");
    c.sum_mask = '0; c.casc_en = 1'b0; cfg = c; casc_in = 1'b1;
    #2 chk(casc_out, 1'b0, "R1 cascade disabled");
    c.casc_en = 1'b1; cfg = c;
    #2 chk(casc_out, 1'b1, "R1 cascade enabled");

    // R12 output enable
    @(negedge clk0); pt = 5'b00100; goe = 2'b10; c.oe_pt = 3'd2;
    c.oe_mode = OE_G0;  cfg = c; #1 chk(pad_oe, 1'b0, "R12 OE0 true");
    c.oe_mode = OE_G0N; cfg = c; #1 chk(pad_oe, 1'b1, "R12 OE0 inverted");
    c.oe_mode = OE_G1;  cfg = c; #1 chk(pad_oe, 1'b1, "R12 OE1 true");
    c.oe_mode = OE_G1N; cfg = c; #1 chk(pad_oe, 1'b0, "R12 OE1 inverted");
    c.oe_mode = OE_PT;  cfg = c; #1 chk(pad_oe, 1'b1, "R12 term OE high");
    pt[2] = 1'b0;               #1 chk(pad_oe, 1'b0, "R12 term OE low");

    summary();
    $finish;
  end
endmodule